// File: doc/BRIEF.md
# Single-wire slave alarm interrupt signaler

This block is the alarm signaling stage of a slave on a single-wire, open-drain bus. It samples the bus level through a synchronizer. It recognises the long low that a master uses as a bus reset and answers each reset with a presence pulse. When an alarm needs attention, it tells the master in one of two ways. It can send its own long low pulse on an idle bus. Or it can keep holding the bus low after the master has let go of a reset, so that the reset becomes longer.

Its single output is a pull-low enable for an open-drain pad. A microsecond timebase, derived from the system clock, times every interval. An alarm is signalled until it is acknowledged. The form of each repeat follows where the most recent transaction on the bus was addressed. The protocol layer reports that target, and the block keeps it as a select flag. The command layer supplies an arm enable and a busy flag, and a spontaneous pulse is sent only when the command layer permits it.

Top module: `ow_irq_signaler`

## Requirements
- R1: While `rst` is high, `bus_pull_low` is 0. After reset is released, the block sends a power-on presence: the bus stays high for 15 to 60 µs, then is pulled low for 60 to 240 µs.
- R2: If the bus stays low for at least 480 µs and is then released, a presence pulse follows with the same high-wait and low-time windows. A shorter low, such as 100 µs, gets no response.
- R3: A new alarm (`alarm_evt` strobe) arrives while the bus is idle and high, `irq_arm` is 1, `link_busy` is 0 and no power-on hold is active. The block then pulls low for INT_US µs (default 1920, within ±1 µs), starting within 2 µs of the strobe. A presence pulse follows.
- R4: An alarm that arrives during a presence pulse does not cut that pulse short. The INT_US pulse starts only after the presence low time has ended, and a second presence pulse follows it.
- R5: If the alarm arrives while `irq_arm` is 0 or `link_busy` is 1, no pulse appears, even after `link_busy` falls. The next master reset is instead held so that the total low time is INT_US µs (within ±3 µs), and a presence pulse follows.
- R6: A new alarm that arrives while the master holds a reset low, at least 480 µs into it, makes the block pull for a full INT_US µs from that moment. The total low time is then the alarm offset plus INT_US.
- R7: After a power-on presence, a new alarm produces no spontaneous pulse. The next master reset is stretched to INT_US µs total, and a presence pulse follows.
- R8: An unacknowledged alarm stretches every following reset while the select flag is 0. After an `irq_ack` strobe, a reset gets only the plain presence response.
- R9: A `xact_done` strobe loads the select flag from `xact_self`. With the flag at 1, each reset of a pending, already-signalled alarm gets a presence pulse, then an INT_US pulse, then another presence pulse. With the flag at 0, the reset is stretched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 1 | Raw bus level (1 = high), asynchronous |
| alarm_evt | input | 1 | One-cycle strobe: a new alarm condition has begun |
| irq_arm | input | 1 | 1 allows a spontaneous interrupt pulse |
| link_busy | input | 1 | 1 while the command layer is communicating |
| irq_ack | input | 1 | One-cycle strobe: the master has acknowledged the alarm |
| xact_done | input | 1 | One-cycle strobe: a transaction has ended |
| xact_self | input | 1 | With `xact_done`: 1 if that transaction addressed this slave |
| bus_pull_low | output | 1 | 1 enables the open-drain pull-down; the block never drives high |

## Verification
The bench models the master's resets and records the start and width of every low pulse on the wired bus. The alarm is tried in four places: on an idle bus, inside a presence pulse, partway into a reset low, and just after power-up. These cases separate the spontaneous pulse from the reset stretch and show which one each timing picks. The blocking conditions (not armed, busy) are checked against the armed case, and the pulse count shows that a missed chance is never sent late. Repeated resets with the select flag at each value, and with and without acknowledge, show the repeat waveform switching between stretch and presence-then-pulse.

// File: rtl/ow_irq_pkg.sv
package ow_irq_pkg;

    // Timing limits of the bus protocol, in microseconds
    localparam int RST_MIN_US = 480;
    localparam int INT_LO_US  = 960;
    localparam int INT_HI_US  = 3840;

    typedef enum logic [2:0] {
        S_IDLE,     // bus high, nothing owed
        S_MLOW,     // master holds the bus low
        S_STRETCH,  // block keeps a reset low
        S_PWAIT,    // high wait before presence
        S_PLOW,     // presence low
        S_IRQ,      // own long interrupt pulse
        S_REL       // released, waiting to see bus high
    } ow_state_e;

    typedef enum logic {
        RET_IDLE,
        RET_PRES
    } ret_e;

    typedef struct packed {
        logic pending;   // alarm not yet acknowledged
        logic fresh;     // alarm not yet signalled at all
        logic try_now;   // one spontaneous attempt owed
        logic owe_long;  // long pulse owed after presence
        logic sel_long;  // repeat waveform: presence then pulse
        logic por_blk;   // no spontaneous pulse until first reset
    } irq_flags_t;

    function automatic int clamp_int_us(input int v);
        if (v < INT_LO_US) return INT_LO_US;
        if (v > INT_HI_US) return INT_HI_US;
        return v;
    endfunction

    function automatic logic drives_low(input ow_state_e s);
        return (s == S_STRETCH) || (s == S_PLOW) || (s == S_IRQ);
    endfunction

endpackage

// File: rtl/ow_sync.sv
module ow_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic s1, s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= RST_VAL;
            s2 <= RST_VAL;
        end else begin
            s1 <= d;
            s2 <= s1;
        end
    end

    assign q = s2;
endmodule

// File: rtl/ow_us_timer.sv
module ow_us_timer #(
    parameter int CYC_PER_US = 50,
    parameter int CW         = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    output logic          us_edge,
    output logic [CW-1:0] cnt_us
);
    generate
        if (CYC_PER_US <= 1) begin : g_direct
            assign us_edge = 1'b1;
        end else begin : g_prescale
            localparam int PW = $clog2(CYC_PER_US);
            localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_US - 1);
            logic [PW-1:0] pre;

            always_ff @(posedge clk) begin
                if (rst || restart)       pre <= '0;
                else if (pre == PRE_LAST) pre <= '0;
                else                      pre <= pre + 1'b1;
            end

            assign us_edge = (pre == PRE_LAST);
        end
    endgenerate

    // Saturating microsecond count since the last restart
    always_ff @(posedge clk) begin
        if (rst || restart)                  cnt_us <= '0;
        else if (us_edge && (cnt_us != '1))  cnt_us <= cnt_us + 1'b1;
    end
endmodule

// File: rtl/ow_irq_fsm.sv
module ow_irq_fsm
    import ow_irq_pkg::*;
#(
    parameter int RST_US   = 480,
    parameter int PWAIT_US = 30,
    parameter int PLOW_US  = 120,
    parameter int INT_US   = 1920,
    parameter int CW       = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_hi,
    input  logic          us_edge,
    input  logic [CW-1:0] cnt_us,
    input  logic          alarm_evt,
    input  logic          irq_arm,
    input  logic          link_busy,
    input  logic          irq_ack,
    input  logic          xact_done,
    input  logic          xact_self,
    output logic          restart,
    output logic          pull_low
);
    localparam logic [CW-1:0] RST_C   = CW'(RST_US);
    localparam logic [CW-1:0] PWAIT_C = CW'(PWAIT_US);
    localparam logic [CW-1:0] PLOW_C  = CW'(PLOW_US);
    localparam logic [CW-1:0] INT_C   = CW'(INT_US);
    localparam logic [CW-1:0] ONE_C   = CW'(1);

    ow_state_e     state, state_n;
    ret_e          ret, ret_n;
    irq_flags_t    flags, f;
    logic [CW-1:0] str_len, str_len_n;
    logic          rst_seen;

    function automatic logic elapsed(input logic [CW-1:0] len);
        return us_edge && (cnt_us == len - ONE_C);
    endfunction

    assign rst_seen = elapsed(RST_C);

    always_comb begin
        state_n   = state;
        ret_n     = ret;
        str_len_n = str_len;
        f         = flags;

        // events from the neighbouring layers
        if (xact_done) f.sel_long = xact_self;
        if (alarm_evt) begin
            f.pending = 1'b1;
            f.fresh   = 1'b1;
            f.try_now = 1'b1;
        end

        case (state)
            S_IDLE: begin
                if (!bus_hi) begin
                    state_n = S_MLOW;
                end else if (f.owe_long) begin
                    f.owe_long = 1'b0;
                    if (f.pending) state_n = S_IRQ;
                end else if (f.try_now) begin
                    f.try_now = 1'b0;
                    if (f.fresh && irq_arm && !link_busy && !f.por_blk) begin
                        state_n = S_IRQ;
                        f.fresh = 1'b0;
                    end
                end
            end
            S_MLOW: begin
                if (bus_hi) begin
                    state_n = (cnt_us >= RST_C) ? S_PWAIT : S_IDLE;
                end else if (rst_seen) begin
                    f.por_blk = 1'b0;
                    f.try_now = 1'b0;
                    if (f.pending) begin
                        if (f.fresh || !f.sel_long) begin
                            state_n   = S_STRETCH;
                            str_len_n = INT_C - RST_C;
                            f.fresh   = 1'b0;
                        end else begin
                            f.owe_long = 1'b1;
                        end
                    end
                end else if ((cnt_us >= RST_C) && f.fresh) begin
                    // alarm raised inside an ongoing reset: full pulse from now
                    state_n    = S_STRETCH;
                    str_len_n  = INT_C;
                    f.fresh    = 1'b0;
                    f.try_now  = 1'b0;
                    f.owe_long = 1'b0;
                end
            end
            S_STRETCH: begin
                if (elapsed(str_len)) begin
                    state_n = S_REL;
                    ret_n   = RET_PRES;
                end
            end
            S_IRQ: begin
                if (elapsed(INT_C)) begin
                    state_n = S_REL;
                    ret_n   = RET_PRES;
                end
            end
            S_PWAIT: begin
                if (elapsed(PWAIT_C)) state_n = S_PLOW;
            end
            S_PLOW: begin
                if (elapsed(PLOW_C)) begin
                    state_n = S_REL;
                    ret_n   = RET_IDLE;
                end
            end
            S_REL: begin
                if (bus_hi) state_n = (ret == RET_PRES) ? S_PWAIT : S_IDLE;
            end
            default: state_n = S_IDLE;
        endcase

        if (irq_ack) begin
            f.pending  = 1'b0;
            f.fresh    = 1'b0;
            f.try_now  = 1'b0;
            f.owe_long = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_PWAIT;   // power-on presence
            ret     <= RET_IDLE;
            str_len <= '0;
            flags   <= '{pending: 1'b0, fresh: 1'b0, try_now: 1'b0,
                         owe_long: 1'b0, sel_long: 1'b0, por_blk: 1'b1};
        end else begin
            state   <= state_n;
            ret     <= ret_n;
            str_len <= str_len_n;
            flags   <= f;
        end
    end

    assign restart  = (state_n != state);
    assign pull_low = drives_low(state);

    // R5: an unarmed alarm never starts a spontaneous pulse
    assert_spont_needs_arm_R5: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && bus_hi && !irq_arm && !flags.owe_long)
        |=> (state != S_IRQ));

    // R5: busy command layer blocks a spontaneous pulse
    assert_spont_not_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && bus_hi && link_busy && !flags.owe_long)
        |=> (state != S_IRQ));

    // R7: power-on hold keeps the bus quiet until a reset is seen
    assert_por_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && flags.por_blk) |=> (state != S_IRQ));

    // R2: a released long low always leads to the presence wait
    assert_presence_after_reset_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_MLOW && bus_hi && cnt_us >= RST_C) |=> (state == S_PWAIT));

    // R2: a short low returns to idle with no answer
    assert_short_low_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_MLOW && bus_hi && cnt_us < RST_C) |=> (state == S_IDLE));

    // R8: acknowledge drops the pending alarm
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !flags.pending);
endmodule

// File: rtl/ow_irq_signaler.sv
module ow_irq_signaler
    import ow_irq_pkg::*;
#(
    parameter int CYC_PER_US = 250,
    parameter int INT_US     = 1920,
    parameter int RST_US     = RST_MIN_US,
    parameter int PWAIT_US   = 30,
    parameter int PLOW_US    = 120
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_in,
    input  logic alarm_evt,
    input  logic irq_arm,
    input  logic link_busy,
    input  logic irq_ack,
    input  logic xact_done,
    input  logic xact_self,
    output logic bus_pull_low
);
    localparam int INT_EFF = clamp_int_us(INT_US);
    localparam int CW      = $clog2(INT_HI_US + RST_US + 1);

    logic          bus_hi;
    logic          restart;
    logic          us_edge;
    logic [CW-1:0] cnt_us;

    ow_sync #(.RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_in),
        .q   (bus_hi)
    );

    ow_us_timer #(.CYC_PER_US(CYC_PER_US), .CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .us_edge (us_edge),
        .cnt_us  (cnt_us)
    );

    ow_irq_fsm #(
        .RST_US   (RST_US),
        .PWAIT_US (PWAIT_US),
        .PLOW_US  (PLOW_US),
        .INT_US   (INT_EFF),
        .CW       (CW)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .bus_hi    (bus_hi),
        .us_edge   (us_edge),
        .cnt_us    (cnt_us),
        .alarm_evt (alarm_evt),
        .irq_arm   (irq_arm),
        .link_busy (link_busy),
        .irq_ack   (irq_ack),
        .xact_done (xact_done),
        .xact_self (xact_self),
        .restart   (restart),
        .pull_low  (bus_pull_low)
    );
endmodule

// File: tb/ow_irq_signaler_bench.sv
`timescale 1ns/1ps
module ow_irq_signaler_bench;
    localparam int CPU  = 2;
    localparam int INTU = 1920;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_low = 1'b0;
    logic alarm_evt = 1'b0, irq_arm = 1'b0, link_busy = 1'b0;
    logic irq_ack = 1'b0, xact_done = 1'b0, xact_self = 1'b0;
    logic pull;
    logic bus;

    int n_run = 0, n_fail = 0;
    int cyc = 0, npulse = 0, fall_t = 0;
    int p_fall [32];
    int p_len  [32];
    logic bus_q = 1'b1;
    bit done = 1'b0;

    always #2 clk = ~clk;
    assign bus = !(m_low || pull);

    ow_irq_signaler #(.CYC_PER_US(CPU), .INT_US(INTU)) u_ow_irq_signaler (
        .clk(clk), .rst(rst), .bus_in(bus), .alarm_evt(alarm_evt),
        .irq_arm(irq_arm), .link_busy(link_busy), .irq_ack(irq_ack),
        .xact_done(xact_done), .xact_self(xact_self), .bus_pull_low(pull)
    );

    // bus monitor: records each low pulse (start cycle, width in cycles)
    always @(negedge clk) begin
        if (bus_q && !bus) fall_t = cyc;
        if (!bus_q && bus && npulse < 32) begin
            p_fall[npulse] = fall_t;
            p_len[npulse]  = cyc - fall_t;
            npulse = npulse + 1;
        end
        bus_q = bus;
        cyc = cyc + 1;
    end

    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_us(input int us);
        step(us * CPU);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int end_of(input int i);
        return p_fall[i] + p_len[i];
    endfunction

    task automatic clear_log();
        npulse = 0;
        for (int i = 0; i < 32; i++) begin
            p_fall[i] = 0;
            p_len[i]  = 0;
        end
    endtask

    task automatic count_is(input string req, input int n);
        chk(npulse == n, req, "pulse count", npulse, n);
    endtask

    task automatic width_near(input string req, input int idx, input int exp_us, input int tol_us);
        int d;
        d = p_len[idx] - exp_us * CPU;
        if (d < 0) d = -d;
        chk(d <= tol_us * CPU, req, "low width (cycles)", p_len[idx], exp_us * CPU);
    endtask

    task automatic presence_ok(input string req, input int idx, input int rise_c);
        int gap;
        gap = p_fall[idx] - rise_c;
        chk(gap >= 15 * CPU && gap <= 60 * CPU, req, "presence wait (cycles)", gap, 30 * CPU);
        chk(p_len[idx] >= 60 * CPU && p_len[idx] <= 240 * CPU, req,
            "presence low (cycles)", p_len[idx], 120 * CPU);
    endtask

    task automatic fire_alarm();
        alarm_evt = 1'b1; step(1); alarm_evt = 1'b0;
    endtask

    task automatic fire_ack();
        irq_ack = 1'b1; step(1); irq_ack = 1'b0;
    endtask

    task automatic fire_xact(input logic self_hit);
        xact_self = self_hit; xact_done = 1'b1; step(1);
        xact_done = 1'b0; xact_self = 1'b0;
    endtask

    task automatic master_low(input int us);
        m_low = 1'b1; wait_us(us); m_low = 1'b0;
    endtask

    // R1: released during reset, power-on presence afterwards
    task automatic t_power_on();
        int rel;
        rst = 1'b1; step(6);
        chk(pull == 1'b0, "R1", "pull during reset", int'(pull), 0);
        clear_log();
        rel = cyc;
        rst = 1'b0;
        wait_us(400);
        count_is("R1", 1);
        presence_ok("R1", 0, rel);
    endtask

    // R2: long low gets presence, short low is ignored
    task automatic t_reset_presence();
        clear_log();
        master_low(500);
        wait_us(400);
        count_is("R2", 2);
        width_near("R2", 0, 500, 2);
        presence_ok("R2", 1, end_of(0));
        clear_log();
        master_low(100);
        wait_us(400);
        count_is("R2", 1);
        width_near("R2", 0, 100, 2);
    endtask

    // R3: spontaneous pulse on an idle armed bus
    task automatic t_spont();
        int t0;
        irq_arm = 1'b1;
        clear_log();
        t0 = cyc;
        fire_alarm();
        wait_us(2300);
        count_is("R3", 2);
        chk(p_fall[0] - t0 <= 2 * CPU, "R3", "start delay (cycles)", p_fall[0] - t0, 2);
        width_near("R3", 0, INTU, 1);
        presence_ok("R3", 1, end_of(0));
        fire_ack();
    endtask

    // R4: alarm during presence waits for it
    task automatic t_in_presence();
        int ta;
        irq_arm = 1'b1;
        clear_log();
        master_low(500);
        wait_us(40);
        ta = cyc;
        fire_alarm();
        wait_us(2500);
        count_is("R4", 4);
        presence_ok("R4", 1, end_of(0));
        chk(p_fall[2] >= end_of(1) && p_fall[2] - ta >= 60 * CPU, "R4",
            "pulse start after alarm (cycles)", p_fall[2] - ta, 110 * CPU);
        width_near("R4", 2, INTU, 1);
        presence_ok("R4", 3, end_of(2));
        fire_ack();
    endtask

    // R5: blocked (unarmed or busy) alarm becomes a reset stretch
    task automatic t_blocked(input bit use_busy);
        irq_arm   = use_busy;
        link_busy = use_busy;
        clear_log();
        fire_alarm();
        wait_us(300);
        count_is("R5", 0);
        link_busy = 1'b0;
        wait_us(100);
        count_is("R5", 0);
        master_low(500);
        wait_us(2500);
        count_is("R5", 2);
        width_near("R5", 0, INTU, 3);
        presence_ok("R5", 1, end_of(0));
        fire_ack();
    endtask

    // R6: alarm inside a reset low adds a full pulse
    task automatic t_in_reset();
        irq_arm = 1'b0;
        clear_log();
        m_low = 1'b1;
        wait_us(600);
        fire_alarm();
        wait_us(200);
        m_low = 1'b0;
        wait_us(2300);
        count_is("R6", 2);
        width_near("R6", 0, 600 + INTU, 3);
        presence_ok("R6", 1, end_of(0));
        fire_ack();
    endtask

    // R7: alarm after power-up waits for the first reset
    task automatic t_por();
        irq_arm = 1'b1;
        rst = 1'b1; step(4); rst = 1'b0;
        wait_us(250);
        clear_log();
        fire_alarm();
        wait_us(300);
        count_is("R7", 0);
        master_low(500);
        wait_us(2500);
        count_is("R7", 2);
        width_near("R7", 0, INTU, 3);
        presence_ok("R7", 1, end_of(0));
        fire_ack();
    endtask

    // R8: repeats on every reset until acknowledged
    task automatic t_repeat();
        irq_arm = 1'b0;
        fire_alarm();
        for (int k = 0; k < 2; k++) begin
            clear_log();
            master_low(500);
            wait_us(2500);
            count_is("R8", 2);
            width_near("R8", 0, INTU, 3);
            presence_ok("R8", 1, end_of(0));
        end
        fire_ack();
        clear_log();
        master_low(500);
        wait_us(400);
        count_is("R8", 2);
        width_near("R8", 0, 500, 2);
        presence_ok("R8", 1, end_of(0));
    endtask

    // R9: waveform select from the last transaction's target
    task automatic t_select();
        irq_arm = 1'b0;
        fire_alarm();
        clear_log();
        master_low(500);
        wait_us(2500);
        width_near("R9", 0, INTU, 3);
        fire_xact(1'b1);
        clear_log();
        master_low(500);
        wait_us(2600);
        count_is("R9", 4);
        width_near("R9", 0, 500, 2);
        presence_ok("R9", 1, end_of(0));
        width_near("R9", 2, INTU, 1);
        presence_ok("R9", 3, end_of(2));
        fire_xact(1'b0);
        clear_log();
        master_low(500);
        wait_us(2500);
        count_is("R9", 2);
        width_near("R9", 0, INTU, 3);
        fire_ack();
    endtask

    initial begin
        t_power_on();
        t_reset_presence();
        t_spont();
        t_in_presence();
        t_blocked(1'b0);
        t_blocked(1'b1);
        t_in_reset();
        t_por();
        t_repeat();
        t_select();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule